// File: doc/BRIEF.md
# I2C Master Command and Receive FIFO Front End

This block sits between a 32-bit register bus and the serial engine of an I2C master. Software queues transfer commands by writing a data/command register. Each write becomes one command entry: a data byte plus per-byte flags that ask for a read, a STOP after the byte, or a RESTART before it. The serial engine takes entries from the head of the command FIFO through a simple pop port. It returns received bytes through a push port into a receive FIFO, and software drains that FIFO by reading the same data/command register.

Software can read level registers that count the valid entries in each FIFO, so free space is the depth minus the level. Two programmable thresholds drive a transmit-empty flag and a receive-full flag. These flags are meant for interrupt or polling logic. A push into a full FIFO or a pop from an empty one is not silently lost: it raises a sticky error flag. Dropping the enable input flushes both FIFOs and clears the error flags.

Top module: `i2c_cmd_fifo_front`

## Requirements
- R1: Register byte offsets are: data/command 0x10, command level 0x74, receive level 0x78, command threshold 0x3c, receive threshold 0x38. Thresholds take write-data bits 5:0, can be written whether or not the block is enabled, and read back zero-extended. Any other offset reads as zero. After reset both levels and both thresholds are zero.
- R2: A write to 0x10 while enabled pushes write-data bits 10:0 as one entry. Bits 7:0 are the byte, bit 8 marks a read request, bit 9 asks for a STOP after the byte and bit 10 asks for a RESTART before it. The engine sees the oldest entry on `engCmd` with the same bit positions.
- R3: Each FIFO holds DEPTH (default 32) entries. Each level register returns the current count of valid entries, from 0 to DEPTH.
- R4: A read of 0x10 returns the oldest received byte in bits 7:0, with the upper bits zero, and removes that byte from the receive FIFO.
- R5: `txEmptyFlag` is high exactly while the command level is less than or equal to the command threshold.
- R6: `rxFullFlag` is high exactly while the receive level is greater than the receive threshold. With a threshold of 0 it rises once one byte is held.
- R7: A push into a full command FIFO is discarded, even if the engine pops in the same cycle, and it sets the sticky `txOverflow`.
- R8: An engine push into a full receive FIFO drops the byte and sets the sticky `rxOverflow`. A software read in the same cycle does not make room for it.
- R9: A read of 0x10 while the receive FIFO is empty returns zero and sets the sticky `rxUnderflow`.
- R10: While `enable` is low, both levels read as zero, `engCmdValid` is low, the three error flags read low and are cleared, and all pushes are ignored. After re-enabling, both FIFOs are empty.
- R11: An engine pop from an empty command FIFO has no effect. A push and a pop in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low flushes the FIFOs |
| regAddr | input | 8 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 11 | Write data, bits 10:0 of the bus word |
| regRdata | output | 32 | Read data, valid in the cycle of `regRd` |
| engCmdValid | output | 1 | A command entry is waiting |
| engCmd | output | 11 | Oldest command entry (zero when none is waiting) |
| engCmdPop | input | 1 | Engine consumes the oldest command entry |
| engRxPush | input | 1 | Engine delivers a received byte |
| engRxData | input | 8 | Received byte |
| txEmptyFlag | output | 1 | Command level at or below its threshold |
| rxFullFlag | output | 1 | Receive level above its threshold |
| txOverflow | output | 1 | Sticky: a command push was discarded |
| rxOverflow | output | 1 | Sticky: a received byte was dropped |
| rxUnderflow | output | 1 | Sticky: the empty receive FIFO was read |

## Verification
The hardest case to reach from the ports is the edge of a full FIFO with traffic on both sides in the same cycle. A software push into a full command FIFO must still be rejected while the engine pops. In the same way, an engine push into a full receive FIFO must be rejected while software reads. The stimulus first fills each FIFO to its exact depth through the register and engine ports. It then issues the colliding push and pop together, and reads the levels back to confirm the counts. A long random phase follows that mixes both sides, threshold changes and short disable pulses, with every output compared against a queue-based model.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam logic [7:0] OFS_DATA   = 8'h10;
  localparam logic [7:0] OFS_TX_LVL = 8'h74;
  localparam logic [7:0] OFS_RX_LVL = 8'h78;
  localparam logic [7:0] OFS_TX_THR = 8'h3c;
  localparam logic [7:0] OFS_RX_THR = 8'h38;
  localparam int CMD_W = 11;

  typedef struct packed {
    logic flush;
    logic cmdPush;
    logic cmdPop;
    logic rxPush;
    logic rxPop;
    logic txOvfSet;
    logic rxOvfSet;
    logic rxUdfSet;
    logic txThrWr;
    logic rxThrWr;
  } fifoCtl_t;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/i2cf_ctrl.sv
module i2cf_ctrl
  import i2cf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             enable,
  input  logic [7:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic             engCmdPop,
  input  logic             engRxPush,
  input  logic [LVL_W-1:0] txCount,
  input  logic [LVL_W-1:0] rxCount,
  output fifoCtl_t         ctl
);
  logic dataWr, dataRd, txFull, rxFull, txNone, rxNone;

  always_comb begin
    dataWr = enable && regWr && (regAddr == OFS_DATA);
    dataRd = enable && regRd && (regAddr == OFS_DATA);
    txFull = (txCount == LVL_W'(DEPTH));
    rxFull = (rxCount == LVL_W'(DEPTH));
    txNone = (txCount == '0);
    rxNone = (rxCount == '0);

    ctl.flush    = !enable;
    ctl.cmdPush  = dataWr && !txFull;
    ctl.txOvfSet = dataWr && txFull;
    ctl.cmdPop   = enable && engCmdPop && !txNone;
    ctl.rxPush   = enable && engRxPush && !rxFull;
    ctl.rxOvfSet = enable && engRxPush && rxFull;
    ctl.rxPop    = dataRd && !rxNone;
    ctl.rxUdfSet = dataRd && rxNone;
    ctl.txThrWr  = regWr && (regAddr == OFS_TX_THR);
    ctl.rxThrWr  = regWr && (regAddr == OFS_RX_THR);
  end
endmodule

// File: rtl/i2cf_datapath.sv
module i2cf_datapath
  import i2cf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  fifoCtl_t         ctl,
  input  logic [7:0]       regAddr,
  input  logic [CMD_W-1:0] regWdata,
  input  logic [7:0]       engRxData,
  output logic [31:0]      regRdata,
  output logic [CMD_W-1:0] engCmd,
  output logic             engCmdValid,
  output logic [LVL_W-1:0] txCount,
  output logic [LVL_W-1:0] rxCount,
  output logic [LVL_W-1:0] txLvl,
  output logic [LVL_W-1:0] rxLvl,
  output logic             txEmptyFlag,
  output logic             rxFullFlag,
  output logic             txOverflow,
  output logic             rxOverflow,
  output logic             rxUnderflow
);
  logic [CMD_W-1:0] cmdHead;
  logic [7:0]       rxHead;
  logic [LVL_W-1:0] txThr, rxThr;
  logic             txOvfQ, rxOvfQ, rxUdfQ;

  i2cf_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdFifo (
    .clk(clk), .rstN(rstN), .flush(ctl.flush), .push(ctl.cmdPush),
    .pop(ctl.cmdPop), .wdata(regWdata), .head(cmdHead), .level(txCount)
  );

  i2cf_fifo #(.W(8), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(ctl.flush), .push(ctl.rxPush),
    .pop(ctl.rxPop), .wdata(engRxData), .head(rxHead), .level(rxCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThr  <= '0;
      rxThr  <= '0;
      txOvfQ <= 1'b0;
      rxOvfQ <= 1'b0;
      rxUdfQ <= 1'b0;
    end else begin
      if (ctl.txThrWr) txThr <= regWdata[LVL_W-1:0];
      if (ctl.rxThrWr) rxThr <= regWdata[LVL_W-1:0];
      if (ctl.flush) begin
        txOvfQ <= 1'b0;
        rxOvfQ <= 1'b0;
        rxUdfQ <= 1'b0;
      end else begin
        txOvfQ <= txOvfQ | ctl.txOvfSet;
        rxOvfQ <= rxOvfQ | ctl.rxOvfSet;
        rxUdfQ <= rxUdfQ | ctl.rxUdfSet;
      end
    end
  end

  always_comb begin
    txLvl       = enable ? txCount : '0;
    rxLvl       = enable ? rxCount : '0;
    engCmdValid = (txLvl != '0);
    engCmd      = engCmdValid ? cmdHead : '0;
    txEmptyFlag = (txLvl <= txThr);
    rxFullFlag  = (rxLvl > rxThr);
    txOverflow  = enable && txOvfQ;
    rxOverflow  = enable && rxOvfQ;
    rxUnderflow = enable && rxUdfQ;
    unique case (regAddr)
      OFS_DATA:   regRdata = (rxLvl != '0) ? {24'd0, rxHead} : 32'd0;
      OFS_TX_LVL: regRdata = 32'(txLvl);
      OFS_RX_LVL: regRdata = 32'(rxLvl);
      OFS_TX_THR: regRdata = 32'(txThr);
      OFS_RX_THR: regRdata = 32'(rxThr);
      default:    regRdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/i2c_cmd_fifo_front.sv
module i2c_cmd_fifo_front
  import i2cf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [7:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [CMD_W-1:0] regWdata,
  output logic [31:0]      regRdata,
  output logic             engCmdValid,
  output logic [CMD_W-1:0] engCmd,
  input  logic             engCmdPop,
  input  logic             engRxPush,
  input  logic [7:0]       engRxData,
  output logic             txEmptyFlag,
  output logic             rxFullFlag,
  output logic             txOverflow,
  output logic             rxOverflow,
  output logic             rxUnderflow
);
  fifoCtl_t         ctl;
  logic [LVL_W-1:0] txCount, rxCount, txLvl, rxLvl;

  i2cf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .enable(enable), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .engCmdPop(engCmdPop), .engRxPush(engRxPush),
    .txCount(txCount), .rxCount(rxCount), .ctl(ctl)
  );

  i2cf_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .ctl(ctl),
    .regAddr(regAddr), .regWdata(regWdata), .engRxData(engRxData),
    .regRdata(regRdata), .engCmd(engCmd), .engCmdValid(engCmdValid),
    .txCount(txCount), .rxCount(rxCount), .txLvl(txLvl), .rxLvl(rxLvl),
    .txEmptyFlag(txEmptyFlag), .rxFullFlag(rxFullFlag),
    .txOverflow(txOverflow), .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow)
  );
endmodule

// File: rtl/i2cf_checker.sv
module i2cf_checker
  import i2cf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [7:0]       regAddr,
  input logic             regWr,
  input logic             regRd,
  input logic             engCmdPop,
  input logic [LVL_W-1:0] txLvl,
  input logic [LVL_W-1:0] rxLvl,
  input logic             engCmdValid,
  input logic             txEmptyFlag,
  input logic             rxFullFlag,
  input logic             txOverflow,
  input logic             rxUnderflow
);
  logic dataWr, dataRd;
  assign dataWr = regWr && (regAddr == OFS_DATA);
  assign dataRd = regRd && (regAddr == OFS_DATA);

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txLvl <= LVL_W'(DEPTH)) && (rxLvl <= LVL_W'(DEPTH)));

  p_push_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && dataWr && txLvl < LVL_W'(DEPTH) && !engCmdPop)
      |=> (!enable || txLvl == LVL_W'($past(txLvl) + 1'b1)));

  p_tx_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txLvl == '0) |-> txEmptyFlag);

  p_rx_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxFullFlag |-> (rxLvl != '0));

  p_full_reject_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && dataWr && txLvl == LVL_W'(DEPTH))
      |=> (!enable || (txOverflow && txLvl >= LVL_W'(DEPTH - 1))));

  p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txOverflow) |=> (!enable || txOverflow));

  p_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && dataRd && rxLvl == '0) |=> (!enable || rxUnderflow));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!enable || (txLvl == '0 && rxLvl == '0 && !txOverflow)));

  p_idle_pop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txLvl == '0 && !dataWr) |=> (!enable || !engCmdValid));
endmodule

bind i2c_cmd_fifo_front i2cf_checker #(.DEPTH(DEPTH)) u_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .regAddr(regAddr),
  .regWr(regWr), .regRd(regRd), .engCmdPop(engCmdPop),
  .txLvl(txLvl), .rxLvl(rxLvl), .engCmdValid(engCmdValid),
  .txEmptyFlag(txEmptyFlag), .rxFullFlag(rxFullFlag),
  .txOverflow(txOverflow), .rxUnderflow(rxUnderflow)
);

// File: tb/test_i2c_cmd_fifo_front.sv
`timescale 1ns/1ps
module test_i2c_cmd_fifo_front;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [10:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        engCmdValid;
  logic [10:0] engCmd;
  logic        engCmdPop = 1'b0, engRxPush = 1'b0;
  logic [7:0]  engRxData = '0;
  logic        txEmptyFlag, rxFullFlag, txOverflow, rxOverflow, rxUnderflow;

  always #10 clk = ~clk;

  i2c_cmd_fifo_front #(.DEPTH(DEPTH)) i_i2c_cmd_fifo_front (
    .clk(clk), .rstN(rstN), .enable(enable), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .engCmdValid(engCmdValid), .engCmd(engCmd), .engCmdPop(engCmdPop),
    .engRxPush(engRxPush), .engRxData(engRxData),
    .txEmptyFlag(txEmptyFlag), .rxFullFlag(rxFullFlag),
    .txOverflow(txOverflow), .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [10:0] cmdQ[$];
  logic [7:0]  rxQ[$];
  int          txThr = 0, rxThr = 0;
  bit          mTxOvf = 0, mRxOvf = 0, mRxUdf = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint expRead(logic [7:0] a);
    case (a)
      8'h10: return (enable && rxQ.size() > 0) ? longint'(rxQ[0]) : 0;
      8'h74: return enable ? cmdQ.size() : 0;
      8'h78: return enable ? rxQ.size() : 0;
      8'h3c: return txThr;
      8'h38: return rxThr;
      default: return 0;
    endcase
  endfunction

  function automatic string readReq(logic [7:0] a);
    case (a)
      8'h10: return "R4";
      8'h74, 8'h78: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic cmpOutputs();
    int tl, rl;
    tl = enable ? cmdQ.size() : 0;
    rl = enable ? rxQ.size() : 0;
    chk("R11", "engCmdValid", engCmdValid, tl > 0);
    if (tl > 0) chk("R2", "engCmd", engCmd, cmdQ[0]);
    chk("R5", "txEmptyFlag", txEmptyFlag, tl <= txThr);
    chk("R6", "rxFullFlag", rxFullFlag, rl > rxThr);
    chk("R7", "txOverflow", txOverflow, enable && mTxOvf);
    chk("R8", "rxOverflow", rxOverflow, enable && mRxOvf);
    chk("R9", "rxUnderflow", rxUnderflow, enable && mRxUdf);
  endtask

  // one clock: drive at negedge, check read data, model at posedge, compare outputs
  task automatic step(bit wr, bit rd, logic [7:0] a, logic [10:0] wd,
                      bit ePop, bit ePush, logic [7:0] eData);
    bit dW, dR;
    int cs, rs;
    regWr = wr; regRd = rd; regAddr = a; regWdata = wd;
    engCmdPop = ePop; engRxPush = ePush; engRxData = eData;
    #1;
    if (rd) chk(readReq(a), "regRdata", regRdata, expRead(a));
    @(posedge clk);
    if (!enable) begin
      cmdQ.delete(); rxQ.delete();
      mTxOvf = 0; mRxOvf = 0; mRxUdf = 0;
    end else begin
      dW = wr && a == 8'h10;
      dR = rd && a == 8'h10;
      cs = cmdQ.size(); rs = rxQ.size();
      if (dW && cs == DEPTH) mTxOvf = 1;
      if (dR && rs == 0) mRxUdf = 1;
      if (ePush && rs == DEPTH) mRxOvf = 1;
      if (ePop && cs > 0) void'(cmdQ.pop_front());
      if (dR && rs > 0) void'(rxQ.pop_front());
      if (dW && cs < DEPTH) cmdQ.push_back(wd);
      if (ePush && rs < DEPTH) rxQ.push_back(eData);
    end
    if (wr && a == 8'h3c) txThr = wd[5:0];
    if (wr && a == 8'h38) rxThr = wd[5:0];
    @(negedge clk);
    regWr = 0; regRd = 0; engCmdPop = 0; engRxPush = 0;
    cmpOutputs();
  endtask

  task automatic wrReg(logic [7:0] a, logic [10:0] d); step(1, 0, a, d, 0, 0, 0); endtask
  task automatic rdReg(logic [7:0] a);                 step(0, 1, a, 0, 0, 0, 0); endtask
  task automatic engPush(logic [7:0] d);               step(0, 0, 0, 0, 0, 1, d); endtask
  task automatic engPop();                             step(0, 0, 0, 0, 1, 0, 0); endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    cmpOutputs();
    rdReg(8'h74); rdReg(8'h78); rdReg(8'h3c); rdReg(8'h38); rdReg(8'h10);
    mRxUdf = 0; enable = 0; step(0, 0, 0, 0, 0, 0, 0); enable = 1; // clear the reset-time underflow
    // R1: thresholds and unmapped offsets
    wrReg(8'h3c, 11'h004); wrReg(8'h38, 11'h000); wrReg(8'h20, 11'h1ff);
    rdReg(8'h3c); rdReg(8'h38); rdReg(8'h20); rdReg(8'h00);
    // R2 / R5: commands with varied flags
    wrReg(8'h10, 11'h0a5); wrReg(8'h10, 11'h100); wrReg(8'h10, 11'h2c3);
    wrReg(8'h10, 11'h4ff); wrReg(8'h10, 11'h75a);
    rdReg(8'h74);
    engPop(); engPop(); rdReg(8'h74);
    // R6 / R4: receive path with threshold 0
    engPush(8'h3c); rdReg(8'h78); engPush(8'h81); engPush(8'hfe);
    rdReg(8'h10); rdReg(8'h10); rdReg(8'h10);
    // R9: underflow
    rdReg(8'h10); rdReg(8'h78);
    // R11: drain commands then pop empty
    repeat (5) engPop();
    rdReg(8'h74);
    // R7: fill command FIFO then push with a concurrent pop
    for (int i = 0; i < DEPTH; i++) wrReg(8'h10, 11'(i * 37));
    rdReg(8'h74);
    step(1, 0, 8'h10, 11'h7ee, 1, 0, 0);
    rdReg(8'h74);
    // R11: push and pop together below full
    step(1, 0, 8'h10, 11'h155, 1, 0, 0); rdReg(8'h74);
    // R8: fill receive FIFO then push with a concurrent read
    wrReg(8'h38, 11'd5);
    for (int i = 0; i < DEPTH; i++) engPush(8'(i + 100));
    rdReg(8'h78);
    step(0, 1, 8'h10, 0, 0, 1, 8'haa);
    rdReg(8'h78);
    // R10: disable flushes and clears flags; pushes ignored
    enable = 0;
    step(1, 0, 8'h10, 11'h011, 0, 1, 8'h22);
    rdReg(8'h74); rdReg(8'h78);
    wrReg(8'h3c, 11'd10); rdReg(8'h3c);
    enable = 1;
    @(negedge clk); cmpOutputs();
    rdReg(8'h74); rdReg(8'h78);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 5) ? 8'h10 : (sel == 5) ? 8'h74 : (sel == 6) ? 8'h78 :
          (sel == 7) ? 8'h3c : (sel == 8) ? 8'h38 : 8'h44;
      if ($urandom_range(0, 199) == 0) enable = 0;
      else if (!enable && $urandom_range(0, 3) == 0) enable = 1;
      if ((a == 8'h3c || a == 8'h38) && $urandom_range(0, 1) == 1)
        step(1, 0, a, 11'($urandom_range(0, DEPTH)), $urandom_range(0, 2) == 0,
             $urandom_range(0, 1) == 1, 8'($urandom));
      else
        step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, 11'($urandom),
             $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, 8'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule